// File: doc/BRIEF.md
# Self-Refreshing Triplicated Voted Register

This block stores one word of feedback state as three redundant copies, one per domain. Each domain has its own data input, its own load enable, its own register and its own majority voter. The voter in a domain looks at all three stored copies and produces that domain's voted word. When the domain's enable is low, its register takes the voted word back in on every clock. A single copy that has been corrupted is therefore outvoted at once and rewritten at the next edge.

The three voted words are brought out, one per domain, so that logic further down each domain can carry on without sharing a wire with the other domains. A fourth voter merges the three voted words into one converged output. A mismatch flag shows when the stored copies disagree, which a test can use to follow a fault from its injection to its repair. A fault is injected through the normal ports by loading one domain with a value that differs from the other two. The stream-style handshake does not apply here: the block holds state and has no flow to throttle, so every pin is plain.

Top module: `tmr_voted_reg`

## Requirements
- R1: A synchronous active-high reset clears all three copies to zero at the next rising edge. Reset wins over the enables. After reset every output is zero and the mismatch flag is low.
- R2: When a domain's enable is high at a rising edge, that domain's copy takes that domain's data input.
- R3: When a domain's enable is low at a rising edge, that domain's copy takes its own voted word, so agreeing copies hold their value.
- R4: Each voted output and the converged output equal the bitwise majority of the three stored copies in the same cycle. One divergent copy never reaches any output.
- R5: A single divergent copy is rewritten to the majority value at the next rising edge at which its enable is low.
- R6: The vote is taken independently per bit: copies that each differ in different bit positions still vote to the common value.
- R7: The mismatch flag is high exactly while the three stored copies are not all equal. It is therefore high for one cycle after a single-copy fault that is then left to heal.
- R8: When two domains load a new value and the third does not, the majority moves to the new value, and the third copy adopts it at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 3 | Load enable, bit k for domain k |
| d0_i | input | WIDTH | Data input of domain 0 |
| d1_i | input | WIDTH | Data input of domain 1 |
| d2_i | input | WIDTH | Data input of domain 2 |
| q0_o | output | WIDTH | Voted word of domain 0 |
| q1_o | output | WIDTH | Voted word of domain 1 |
| q2_o | output | WIDTH | Voted word of domain 2 |
| q_o | output | WIDTH | Converged output from the final voter |
| mismatch_o | output | 1 | High while the stored copies disagree |

## Verification
A load in one domain and the voted refresh in the other two happen on the same edge. The bench provokes this by raising one enable alone with a differing data word. It judges the result in the following cycle: every voted output must still show the old majority, and the mismatch flag must be high. On the next edge, with the enables low, the repair of the odd copy and the fall of the mismatch flag happen together. Both are checked in the cycle after that edge. A second case has two domains load together and checks that the majority moves and the third copy follows.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NUM_DOM = 3;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] c_i,
  output logic [WIDTH-1:0] y_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign y_o[b] = tmr_pkg::maj3(a_i[b], b_i[b], c_i[b]);
  end
endmodule

// File: rtl/tmr_domain.sv
module tmr_domain #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] cp_a_i,
  input  logic [WIDTH-1:0] cp_b_i,
  input  logic [WIDTH-1:0] cp_c_i,
  output logic [WIDTH-1:0] store_o,
  output logic [WIDTH-1:0] voted_o
);
  logic [WIDTH-1:0] store_q;

  tmr_voter #(.WIDTH(WIDTH)) u_vote (
    .a_i(cp_a_i), .b_i(cp_b_i), .c_i(cp_c_i), .y_o(voted_o)
  );

  always_ff @(posedge clk) begin
    if (rst)       store_q <= '0;
    else if (en_i) store_q <= d_i;
    else           store_q <= voted_o;
  end

  assign store_o = store_q;

  // R3
  hold_refresh_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> store_q == $past(voted_o));

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    en_i |=> store_q == $past(d_i));
endmodule

// File: rtl/tmr_voted_reg.sv
module tmr_voted_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       en_i,
  input  logic [WIDTH-1:0] d0_i,
  input  logic [WIDTH-1:0] d1_i,
  input  logic [WIDTH-1:0] d2_i,
  output logic [WIDTH-1:0] q0_o,
  output logic [WIDTH-1:0] q1_o,
  output logic [WIDTH-1:0] q2_o,
  output logic [WIDTH-1:0] q_o,
  output logic             mismatch_o
);
  localparam int unsigned ND = tmr_pkg::NUM_DOM;

  logic [WIDTH-1:0] din   [ND];
  logic [WIDTH-1:0] copy  [ND];
  logic [WIDTH-1:0] voted [ND];

  assign din[0] = d0_i;
  assign din[1] = d1_i;
  assign din[2] = d2_i;

  for (genvar k = 0; k < ND; k++) begin : g_dom
    tmr_domain #(.WIDTH(WIDTH)) u_dom (
      .clk    (clk),
      .rst    (rst),
      .en_i   (en_i[k]),
      .d_i    (din[k]),
      .cp_a_i (copy[0]),
      .cp_b_i (copy[1]),
      .cp_c_i (copy[2]),
      .store_o(copy[k]),
      .voted_o(voted[k])
    );
  end

  tmr_voter #(.WIDTH(WIDTH)) u_final (
    .a_i(voted[0]), .b_i(voted[1]), .c_i(voted[2]), .y_o(q_o)
  );

  assign q0_o = voted[0];
  assign q1_o = voted[1];
  assign q2_o = voted[2];
  assign mismatch_o = (copy[0] != copy[1]) || (copy[1] != copy[2]);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (q_o == '0) && !mismatch_o);

  // R4
  voted_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (q0_o == q_o) && (q1_o == q_o) && (q2_o == q_o));

  // R5
  heal_next_chk: assert property (@(posedge clk) disable iff (rst)
    (mismatch_o && en_i == 3'b000) |=> !mismatch_o);

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!mismatch_o && en_i == 3'b000) |=> $stable(q_o) && !mismatch_o);
endmodule

// File: tb/tmr_voted_reg_tb.sv
module tmr_voted_reg_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   en  = 3'b000;
  logic [W-1:0] d0 = '0, d1 = '0, d2 = '0;
  logic [W-1:0] q0, q1, q2, q;
  logic         mm;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  tmr_voted_reg #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .en_i(en), .d0_i(d0), .d1_i(d1), .d2_i(d2),
    .q0_o(q0), .q1_o(q1), .q2_o(q2), .q_o(q), .mismatch_o(mm)
  );

  task automatic chk_all(input string req, input logic [W-1:0] exp);
    n_run++;
    if (q0 !== exp || q1 !== exp || q2 !== exp || q !== exp) begin
      n_fail++;
      $display("FAIL %s: q0=%h q1=%h q2=%h q=%h expected %h", req, q0, q1, q2, q, exp);
    end
  endtask

  task automatic chk_mm(input string req, input logic exp);
    n_run++;
    if (mm !== exp) begin
      n_fail++;
      $display("FAIL %s: mismatch=%b expected %b", req, mm, exp);
    end
  endtask

  // one edge with the given stimulus, sampled at the following falling edge
  task automatic step(input logic r, input logic [2:0] e,
                      input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    rst = r; en = e; d0 = a; d1 = b; d2 = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    step(1'b1, 3'b111, 8'hFF, 8'hFF, 8'hFF);
    chk_all("R1 reset beats enable", 8'h00);
    chk_mm("R1 reset mismatch", 1'b0);
  endtask

  task automatic t_load_all;
    step(1'b0, 3'b111, 8'hA5, 8'hA5, 8'hA5);
    chk_all("R2 load all", 8'hA5);
    chk_mm("R2 load mismatch", 1'b0);
  endtask

  task automatic t_hold;
    step(1'b0, 3'b000, 8'h11, 8'h22, 8'h33);
    step(1'b0, 3'b000, 8'h44, 8'h55, 8'h66);
    chk_all("R3 hold ignores data", 8'hA5);
    chk_mm("R3 hold mismatch", 1'b0);
  endtask

  task automatic t_single_fault;
    step(1'b0, 3'b010, 8'h00, 8'h3C, 8'h00);
    chk_all("R4 single fault outvoted", 8'hA5);
    chk_mm("R7 mismatch after fault", 1'b1);
    step(1'b0, 3'b000, 8'h00, 8'h00, 8'h00);
    chk_mm("R5 healed next edge", 1'b0);
    chk_all("R5 value after heal", 8'hA5);
  endtask

  task automatic t_bitwise;
    step(1'b0, 3'b011, 8'hA4, 8'hA7, 8'h00);
    chk_all("R6 per-bit vote", 8'hA5);
    chk_mm("R7 mismatch two faulty copies", 1'b1);
    step(1'b0, 3'b000, 8'h00, 8'h00, 8'h00);
    chk_mm("R6 all copies healed", 1'b0);
    chk_all("R6 value after heal", 8'hA5);
  endtask

  task automatic t_double;
    step(1'b0, 3'b101, 8'h5A, 8'h00, 8'h5A);
    chk_all("R8 majority moves", 8'h5A);
    chk_mm("R8 mismatch after two-domain load", 1'b1);
    step(1'b0, 3'b000, 8'h00, 8'h00, 8'h00);
    chk_mm("R8 third copy follows", 1'b0);
    step(1'b0, 3'b001, 8'h00, 8'h00, 8'h00);
    chk_all("R8 copy 0 outvoted by followers", 8'h5A);
    step(1'b0, 3'b000, 8'h00, 8'h00, 8'h00);
    chk_mm("R5 second heal", 1'b0);
  endtask

  task automatic t_reset_again;
    step(1'b1, 3'b000, 8'h00, 8'h00, 8'h00);
    chk_all("R1 reset from loaded state", 8'h00);
    step(1'b0, 3'b000, 8'h00, 8'h00, 8'h00);
    chk_all("R3 zero held", 8'h00);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_load_all();
    t_hold();
    t_single_fault();
    t_bitwise();
    t_double();
    t_reset_again();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule